// File: doc/BRIEF.md
# Watchdog Supervisor with Reset-Cause Tracking

This block watches a small 8-bit controller for a stalled program. A free-running counter measures time since the last restart. When it reaches the selected interval, the block raises a watchdog flag, which can request an interrupt. A grace period of a fixed number of clocks then begins. If software has armed the reset function and the grace period runs out without a restart, the block emits a one-clock reset request. The three system reset sources (power-on, power-fail and external) each leave their own pattern in a power-on flag and a watchdog-caused flag. Firmware reads these flags after boot to learn why the chip restarted.

Software talks to the block through an 8-bit control register at address 0 and a key register at address 1. Four control bits are guarded. These are the restart strobe, the reset-arm bit, the power-on flag and the watchdog flag. A guarded write takes effect only inside a short window. The window opens after a two-byte key sequence is written to the key register. The remaining control bits can be written at any time. All of the reset inputs are synchronous and active high. They are prioritised power-on first, then power-fail, then external.

Top module: `wdt_supervisor`

## Requirements
- R1: With the interval select in control bits [6:5] equal to s, the watchdog flag (bit 3) becomes 1 exactly 2^(BASE_EXP + STEP_EXP*s) clocks after a restart.
- R2: `irq_o` is 1 exactly when the watchdog flag is 1 and `irq_en_i` is 1.
- R3: GRACE clocks after a timeout, if the reset-arm bit (bit 1) is 1, `rst_req_o` is high for exactly one clock.
- R4: If the reset-arm bit is 0 when the grace period ends, `rst_req_o` stays low and the watchdog-reset flag (bit 4) keeps its value.
- R5: A restart is a guarded write with bit 0 set. It clears the counter and cancels a pending grace period, so the next reset request comes only a full interval plus GRACE after it. Bit 0 always reads 0.
- R6: The watchdog-reset flag is set on the clock the reset request rises. Software clears it with an ordinary write of 0 to bit 4.
- R7: Writing 0xAA and then 0x55 to address 1 on back-to-back clocks opens a window for the next 3 clocks. If the two writes are not back to back, no window opens. The first control write inside the window uses it up.
- R8: A control write outside the window leaves bits 0 to 3 unchanged and still updates bits 4 to 6. A control write inside the window updates all of them, and can clear the power-on flag (bit 2).
- R9: A power-on reset sets the power-on flag. It clears the reset-arm bit, the watchdog-reset flag, the watchdog flag and the interval select.
- R10: A power-fail reset clears the watchdog-reset flag, the watchdog flag and the select. It keeps the reset-arm bit and the power-on flag.
- R11: An external reset clears the watchdog flag, the select and the counters. It keeps the watchdog-reset flag, the reset-arm bit and the power-on flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_i | input | 1 | Power-on reset, synchronous, active high |
| pfail_i | input | 1 | Power-fail reset, synchronous, active high |
| ext_i | input | 1 | External reset, synchronous, active high |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 1 | 0 selects the control register, 1 selects the key register |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Control register read value (0 when address 1 is selected) |
| irq_en_i | input | 1 | Watchdog interrupt enable from the interrupt controller |
| irq_o | output | 1 | Watchdog interrupt request |
| rst_req_o | output | 1 | One-clock watchdog reset request |

## Verification
The embedded properties are checked on every clock. They cover:
- the single-cycle width of the reset request;
- the link between that pulse and the watchdog-reset flag;
- the flag pattern after power-on and external resets;
- the rule that the reset-arm bit changes only through an open window;
- window opening only after the second key;
- the loss of a pending grace period on restart.

Only the bench scenarios can show the timing values themselves. These are the exact interval for every select value, the exact grace length, the window's boundary at the third clock, and the silence when the reset-arm bit is clear.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
   // control register bit positions
   localparam int unsigned B_RESTART = 0;
   localparam int unsigned B_ARM     = 1;
   localparam int unsigned B_PORF    = 2;
   localparam int unsigned B_WDF     = 3;
   localparam int unsigned B_WRF     = 4;
   localparam int unsigned B_SEL_LO  = 5;
   localparam int unsigned B_SEL_HI  = 6;
   localparam int unsigned SEL_W     = 2;
   localparam int unsigned N_SEL     = 4;
   // key sequence for the guarded window
   localparam logic [7:0] KEY_FIRST  = 8'hAA;
   localparam logic [7:0] KEY_SECOND = 8'h55;
endpackage

// File: rtl/wdt_unlock.sv
module wdt_unlock #(
   parameter int unsigned WIN_LEN = 3
) (
   input  logic       clk,
   input  logic       clr,
   input  logic       key_wr,
   input  logic [7:0] key_data,
   input  logic       consume,
   output logic       win_open
);
   import wdt_pkg::*;
   localparam int unsigned WIN_W = $clog2(WIN_LEN + 1);

   logic             armed_q;
   logic [WIN_W-1:0] win_q;
   logic             second_hit;

   initial begin
      assert (WIN_LEN >= 1) else $error("WIN_LEN must be at least 1");
   end

   assign second_hit = key_wr && (key_data == KEY_SECOND) && armed_q;
   assign win_open   = (win_q != '0);

   always_ff @(posedge clk) begin
      if (clr) begin
         armed_q <= 1'b0;
         win_q   <= '0;
      end else begin
         armed_q <= key_wr && (key_data == KEY_FIRST);
         if (second_hit)
            win_q <= WIN_W'(WIN_LEN);
         else if (consume)
            win_q <= '0;
         else if (win_q != '0)
            win_q <= win_q - 1'b1;
      end
   end

   // R7
   win_key_chk: assert property (@(posedge clk) disable iff (clr)
      $rose(win_open) |-> $past(key_wr && key_data == KEY_SECOND));
endmodule

// File: rtl/wdt_timebase.sv
module wdt_timebase #(
   parameter int unsigned BASE_EXP = 17,
   parameter int unsigned STEP_EXP = 3
) (
   input  logic       clk,
   input  logic       clr,
   input  logic       hold,
   input  logic [1:0] sel,
   output logic       tmo
);
   import wdt_pkg::*;
   localparam int unsigned CNT_W = BASE_EXP + STEP_EXP * (N_SEL - 1);

   logic [CNT_W-1:0] cnt_q;
   logic [N_SEL-1:0] hit;

   initial begin
      assert (BASE_EXP >= 1 && CNT_W <= 40) else $error("bad timebase exponents");
   end

   for (genvar g = 0; g < N_SEL; g++) begin : g_lim
      localparam int unsigned EXP = BASE_EXP + STEP_EXP * g;
      localparam logic [CNT_W-1:0] LIM = {CNT_W{1'b1}} >> (CNT_W - EXP);
      assign hit[g] = (cnt_q == LIM);
   end

   assign tmo = hit[sel] && !hold && !clr;

   always_ff @(posedge clk) begin
      if (clr || tmo)
         cnt_q <= '0;
      else if (!hold)
         cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/wdt_grace.sv
module wdt_grace #(
   parameter int unsigned GRACE = 512
) (
   input  logic clk,
   input  logic clr,
   input  logic start,
   output logic pending,
   output logic fire
);
   localparam int unsigned G_W = $clog2(GRACE);

   logic [G_W-1:0] gcnt_q;
   logic           pend_q;

   initial begin
      assert (GRACE >= 2) else $error("GRACE must be at least 2");
   end

   assign pending = pend_q;
   assign fire    = pend_q && (gcnt_q == G_W'(GRACE - 1));

   always_ff @(posedge clk) begin
      if (clr) begin
         pend_q <= 1'b0;
         gcnt_q <= '0;
      end else if (start) begin
         pend_q <= 1'b1;
         gcnt_q <= '0;
      end else if (fire) begin
         pend_q <= 1'b0;
         gcnt_q <= '0;
      end else if (pend_q) begin
         gcnt_q <= gcnt_q + 1'b1;
      end
   end

   // R5
   grace_cancel_chk: assert property (@(posedge clk) disable iff (clr)
      $past(clr) |-> !pending);
endmodule

// File: rtl/wdt_supervisor.sv
module wdt_supervisor #(
   parameter int unsigned BASE_EXP = 17,
   parameter int unsigned STEP_EXP = 3,
   parameter int unsigned GRACE    = 512,
   parameter int unsigned WIN_LEN  = 3
) (
   input  logic       clk,
   input  logic       por_i,
   input  logic       pfail_i,
   input  logic       ext_i,
   input  logic       wr_en_i,
   input  logic       addr_i,
   input  logic [7:0] wdata_i,
   output logic [7:0] rdata_o,
   input  logic       irq_en_i,
   output logic       irq_o,
   output logic       rst_req_o
);
   import wdt_pkg::*;

   logic             arm_q, porf_q, wdf_q, wrf_q, rst_q;
   logic [SEL_W-1:0] sel_q;
   logic             any_rst, wr_ctrl, wr_key, prot_ok, restart;
   logic             win_open, tmo, pending, fire;

   assign any_rst = por_i | pfail_i | ext_i;
   assign wr_ctrl = wr_en_i && !addr_i;
   assign wr_key  = wr_en_i && addr_i;
   assign prot_ok = wr_ctrl && win_open;
   assign restart = prot_ok && wdata_i[B_RESTART];

   wdt_unlock #(.WIN_LEN(WIN_LEN)) u_unlock (
      .clk(clk), .clr(any_rst), .key_wr(wr_key), .key_data(wdata_i),
      .consume(prot_ok), .win_open(win_open));

   wdt_timebase #(.BASE_EXP(BASE_EXP), .STEP_EXP(STEP_EXP)) u_timebase (
      .clk(clk), .clr(any_rst | restart), .hold(pending), .sel(sel_q), .tmo(tmo));

   wdt_grace #(.GRACE(GRACE)) u_grace (
      .clk(clk), .clr(any_rst | restart), .start(tmo),
      .pending(pending), .fire(fire));

   always_ff @(posedge clk) begin
      if (por_i) begin
         arm_q  <= 1'b0;
         porf_q <= 1'b1;
         wdf_q  <= 1'b0;
         wrf_q  <= 1'b0;
         sel_q  <= '0;
         rst_q  <= 1'b0;
      end else if (pfail_i) begin
         wdf_q  <= 1'b0;
         wrf_q  <= 1'b0;
         sel_q  <= '0;
         rst_q  <= 1'b0;
      end else if (ext_i) begin
         wdf_q  <= 1'b0;
         sel_q  <= '0;
         rst_q  <= 1'b0;
      end else begin
         rst_q <= fire && arm_q;
         if (wr_ctrl) begin
            sel_q <= wdata_i[B_SEL_HI:B_SEL_LO];
            wrf_q <= wdata_i[B_WRF];
         end
         if (prot_ok) begin
            arm_q  <= wdata_i[B_ARM];
            porf_q <= wdata_i[B_PORF];
            wdf_q  <= wdata_i[B_WDF];
         end
         if (tmo)
            wdf_q <= 1'b1;
         if (fire && arm_q) begin
            wrf_q <= 1'b1;
            wdf_q <= 1'b0;
         end
      end
   end

   always_comb begin
      rdata_o = '0;
      if (!addr_i) begin
         rdata_o[B_ARM]             = arm_q;
         rdata_o[B_PORF]            = porf_q;
         rdata_o[B_WDF]             = wdf_q;
         rdata_o[B_WRF]             = wrf_q;
         rdata_o[B_SEL_HI:B_SEL_LO] = sel_q;
      end
   end

   assign irq_o     = wdf_q && irq_en_i;
   assign rst_req_o = rst_q;

   // R3
   rst_one_clk_chk: assert property (@(posedge clk) disable iff (any_rst)
      rst_req_o |=> !rst_req_o);
   // R6
   wrf_with_rst_chk: assert property (@(posedge clk) disable iff (any_rst)
      rst_req_o |-> wrf_q);
   // R9
   por_pattern_chk: assert property (@(posedge clk) disable iff (any_rst)
      $past(por_i) |-> (porf_q && !arm_q && !wrf_q && !wdf_q));
   // R11
   ext_keep_chk: assert property (@(posedge clk) disable iff (any_rst)
      ($past(ext_i) && !$past(por_i) && !$past(pfail_i))
         |-> (wrf_q == $past(wrf_q) && arm_q == $past(arm_q)));
   // R8
   arm_guard_chk: assert property (@(posedge clk) disable iff (any_rst)
      (!$past(any_rst) && arm_q != $past(arm_q)) |-> $past(win_open));
endmodule

// File: tb/wdt_supervisor_tb.sv
`timescale 1ns/1ps
module wdt_supervisor_tb;
   localparam int BASE = 4;
   localparam int STEP = 3;
   localparam int GR   = 512;

   logic       clk = 1'b0;
   logic       por_i = 1'b1, pfail_i = 1'b0, ext_i = 1'b0;
   logic       wr_en_i = 1'b0, addr_i = 1'b0;
   logic [7:0] wdata_i = '0;
   logic [7:0] rdata_o;
   logic       irq_en_i = 1'b0, irq_o, rst_req_o;

   int nchk = 0, nbad = 0;
   bit done = 0;

   always #2 clk = ~clk;

   wdt_supervisor #(.BASE_EXP(BASE), .STEP_EXP(STEP), .GRACE(GR), .WIN_LEN(3)) u_dut (
      .clk(clk), .por_i(por_i), .pfail_i(pfail_i), .ext_i(ext_i),
      .wr_en_i(wr_en_i), .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
      .irq_en_i(irq_en_i), .irq_o(irq_o), .rst_req_o(rst_req_o));

   task automatic check(input string tag, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nbad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] mk(input int sel, input bit wrf, input bit wdf,
                                     input bit porf, input bit arm, input bit rs);
      return {1'b0, sel[1:0], wrf, wdf, porf, arm, rs};
   endfunction

   task automatic idle(input int n);
      repeat (n) begin
         @(negedge clk);
         wr_en_i = 1'b0; addr_i = 1'b0; wdata_i = '0;
      end
   endtask

   task automatic wr(input bit a, input logic [7:0] d);
      @(negedge clk);
      wr_en_i = 1'b1; addr_i = a; wdata_i = d;
   endtask

   task automatic unlock();
      wr(1'b1, 8'hAA);
      wr(1'b1, 8'h55);
   endtask

   task automatic pulse(input int kind);
      @(negedge clk);
      wr_en_i = 1'b0; addr_i = 1'b0;
      if (kind == 0) por_i = 1'b1; else if (kind == 1) pfail_i = 1'b1; else ext_i = 1'b1;
      @(negedge clk);
      por_i = 1'b0; pfail_i = 1'b0; ext_i = 1'b0;
      idle(1);
   endtask

   // count negedges after the last drive until the watchdog flag reads 1
   task automatic wait_wdf(output int n);
      n = 0;
      do begin
         idle(1);
         n++;
      end while (!rdata_o[3] && n < 20000);
   endtask

   initial begin
      #(4 * 200000);
      nbad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
   end

   initial begin
      int n, g, lim;
      idle(3);
      por_i = 1'b0;
      idle(1);
      // R9 reset state
      check("R9 reset value", int'(rdata_o), 8'h04);
      check("R3 reset rst_req", int'(rst_req_o), 0);

      // R1 R2 R3 R6 interval and grace sweep
      for (int s = 0; s < 4; s++) begin
         lim = 1 << (BASE + STEP * s);
         pulse(0);
         irq_en_i = s[0];
         unlock();
         wr(1'b0, mk(s, 0, 0, 1, 1, 1));
         wait_wdf(n);
         check("R1 interval", n - 1, lim);
         check("R2 irq", int'(irq_o), s[0]);
         g = 0;
         while (!rst_req_o && g < 20000) begin
            idle(1);
            g++;
         end
         check("R3 grace length", g, GR);
         check("R6 flag on pulse", int'(rdata_o[4]), 1);
         check("R2 irq after wd reset", int'(irq_o), 0);
         idle(1);
         check("R3 one clock", int'(rst_req_o), 0);
         wr(1'b0, mk(s, 0, 0, 1, 1, 0));
         idle(1);
         check("R6 software clear", int'(rdata_o[4]), 0);
         check("R8 free sel write", int'(rdata_o[6:5]), s);
      end
      irq_en_i = 1'b0;

      // R4 reset function disarmed, flag preset to 1 keeps value
      pulse(0);
      wr(1'b0, mk(0, 1, 0, 1, 0, 0));
      unlock();
      wr(1'b0, mk(0, 1, 0, 1, 0, 1));
      g = 0;
      for (int i = 0; i < 16 + GR + 40; i++) begin
         idle(1);
         if (rst_req_o) g++;
      end
      check("R4 no pulse", g, 0);
      check("R4 flag kept", int'(rdata_o[4]), 1);

      // R5 restart inside grace period
      pulse(0);
      unlock();
      wr(1'b0, mk(0, 0, 0, 1, 1, 1));
      wait_wdf(n);
      idle(100);
      unlock();
      wr(1'b0, mk(0, 0, 0, 1, 1, 1));
      n = 0;
      do begin
         idle(1);
         n++;
         if (n == 1) check("R5 restart reads 0", int'(rdata_o[0]), 0);
      end while (!rst_req_o && n < 5000);
      check("R5 pulse delayed", n, 16 + GR + 1);

      // R7 window length sweep
      for (int k = 0; k < 5; k++) begin
         pulse(0);
         unlock();
         if (k > 0) idle(k);
         wr(1'b0, mk(0, 0, 0, 1, 1, 0));
         idle(1);
         check("R7 window edge", int'(rdata_o[1]), (k <= 2) ? 1 : 0);
      end
      // R7 keys not back to back
      pulse(0);
      wr(1'b1, 8'hAA);
      idle(1);
      wr(1'b1, 8'h55);
      wr(1'b0, mk(0, 0, 0, 1, 1, 0));
      idle(1);
      check("R7 split keys", int'(rdata_o[1]), 0);
      // R7 second key alone
      pulse(0);
      wr(1'b1, 8'h55);
      wr(1'b0, mk(0, 0, 0, 1, 1, 0));
      idle(1);
      check("R7 lone key", int'(rdata_o[1]), 0);
      // R7 one write consumes the window
      pulse(0);
      unlock();
      wr(1'b0, mk(0, 0, 0, 1, 1, 0));
      wr(1'b0, mk(0, 0, 0, 1, 0, 0));
      idle(1);
      check("R7 consumed", int'(rdata_o[1]), 1);

      // R8 guarded bits ignored without window, free bits taken
      pulse(0);
      wr(1'b0, mk(2, 1, 1, 0, 1, 0));
      idle(1);
      check("R8 guarded ignored", int'(rdata_o[3:0]), 4'b0100);
      check("R8 free taken", int'(rdata_o[6:4]), 3'b101);

      // R9 R10 R11 reset-cause patterns
      pulse(0);
      unlock();
      wr(1'b0, mk(1, 1, 0, 0, 1, 0));
      idle(1);
      check("R8 porf cleared in window", int'(rdata_o[2]), 0);
      pulse(2);
      check("R11 ext pattern", int'(rdata_o), 8'h12);
      pulse(1);
      check("R10 pfail pattern", int'(rdata_o), 8'h02);
      wr(1'b0, mk(3, 1, 0, 0, 0, 0));
      pulse(0);
      check("R9 por pattern", int'(rdata_o), 8'h04);

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
   end
endmodule